// File: doc/BRIEF.md
# Display Raster Field Sequencer

This block produces the vertical timing for the display side of a television memory controller that doubles the field rate. It counts clock cycles inside each line and half-lines inside each field. From those counts it drives a one-cycle line-start pulse, a one-cycle field-start pulse, an A/B field label and the number of the current line within the field. Field lengths are held as half-line counts, so a field may end, and the next one begin, at the midpoint of a line.

A two-bit mode input picks one of four rasters. Bit 1 is the vertical frequency bit and bit 0 is the raster bit. A standard-select input picks the line length. Both inputs are sampled once per field, at its boundary, and again during reset. The field lengths derive from the parameter `BASE_HALVES`, the number of half-lines in a 100 Hz field (625 by default, which is 312.5 lines).

Top module: `raster_field_sequencer`

## Requirements
- R1: With `std_sel`=0 a line lasts `LINE_50` cycles (864 by default). With `std_sel`=1 it lasts `LINE_60` cycles (858 by default). `line_start` is high for one cycle at the first cycle of every line.
- R2: Mode 00 (100 Hz, ABAB) makes every field `BASE_HALVES` half-lines long. `field_id` reads 0,1,0,1 over successive fields.
- R3: Mode 01 (100 Hz, AABB) gives field lengths of `BASE_HALVES`+1, `BASE_HALVES`, `BASE_HALVES`-1 and `BASE_HALVES` half-lines, repeating in that order. `field_id` reads 0,0,1,1.
- R4: Mode 10 (50 Hz, 1:1) makes every field 2·`BASE_HALVES` half-lines long, and `field_id` stays 0.
- R5: Mode 11 (50 Hz, 2:1) alternates fields of 2·`BASE_HALVES`+1 and 2·`BASE_HALVES`-1 half-lines. `field_id` reads 0,1.
- R6: A field with an odd half-line count ends at the midpoint of a line. The next field's `field_start` then falls half a line after a `line_start`, and the line grid keeps running unbroken.
- R7: A new `mode_sel` or `std_sel` value takes effect only at the next field start. A changed mode begins at the first field of its sequence.
- R8: A synchronous reset with `rst_n` low clears the block to the first cycle of the first field. In that state `field_start`=1, `line_start`=1, `line_num`=1 and `field_id`=0, and the mode inputs are captured.
- R9: `line_num` is 1 from each field start and rises by one at every `line_start` that is not also a field start.
- R10: `field_start` is high for exactly one cycle per field, at that field's first cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Display clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_sel | input | 2 | Raster mode: bit 1 is the vertical frequency bit, bit 0 is the raster bit |
| std_sel | input | 1 | Line length: 0 gives `LINE_50`, 1 gives `LINE_60` |
| line_start | output | 1 | One-cycle pulse at the start of each line |
| field_start | output | 1 | One-cycle pulse at the start of each field |
| field_id | output | 1 | A/B field label, A = 0 |
| line_num | output | LN_W | Line number within the field, counting from 1 |

## Verification
The assertions assume that `mode_sel` and `std_sel` do not change while `rst_n` is low. Under that assumption the captured mode changes only on a field-start cycle. The pulse checks also assume a line of at least two cycles and `BASE_HALVES` of at least two. The bench keeps within these limits: it changes the mode inputs only while reset is released, in the middle of fields, and uses short even line lengths. A per-cycle arithmetic model then checks every mode and standard combination over several whole field sequences.

// File: rtl/raster_pkg.sv
// Package raster_pkg
// Shared mode type and per-field arithmetic for the raster sequencer.
// Assumes base >= 2 so that no field length reaches zero.
package raster_pkg;

    typedef enum logic [1:0] {
        RM_ABAB = 2'b00,
        RM_AABB = 2'b01,
        RM_PROG = 2'b10,
        RM_INTL = 2'b11
    } raster_mode_e;

    // Half-line count of the field at position s of the sequence for mode m.
    function automatic int field_halves(raster_mode_e m, logic [1:0] s, int base);
        case (m)
            RM_ABAB: return base;
            RM_AABB: begin
                if (s == 2'd0)      return base + 1;
                else if (s == 2'd2) return base - 1;
                else                return base;
            end
            RM_PROG: return 2 * base;
            default: return s[0] ? (2 * base - 1) : (2 * base + 1);
        endcase
    endfunction

    // A/B label of the field at position s of the sequence for mode m.
    function automatic logic field_label(raster_mode_e m, logic [1:0] s);
        case (m)
            RM_ABAB: return s[0];
            RM_AABB: return s[1];
            RM_PROG: return 1'b0;
            default: return s[0];
        endcase
    endfunction

endpackage

// File: rtl/raster_line_timer.sv
// Module raster_line_timer
// Counts clock cycles inside a line and marks the ends of the half-lines.
// At a field boundary that falls in mid-line it jumps straight to the midpoint of
// the line length chosen for the next field.
// Assumes both line lengths are even and at least 2.
module raster_line_timer #(
    parameter int LINE_50 = 864,
    parameter int LINE_60 = 858,
    localparam int LMAX   = (LINE_50 > LINE_60) ? LINE_50 : LINE_60,
    localparam int CYC_W  = $clog2(LMAX)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic std_cur,
    input  logic std_nxt,
    input  logic wrap,
    output logic line_start,
    output logic line_end,
    output logic half_tick,
    output logic half_begin
);

    localparam logic [CYC_W-1:0] LAST_50 = CYC_W'(LINE_50 - 1);
    localparam logic [CYC_W-1:0] LAST_60 = CYC_W'(LINE_60 - 1);
    localparam logic [CYC_W-1:0] HALF_50 = CYC_W'(LINE_50 / 2);
    localparam logic [CYC_W-1:0] HALF_60 = CYC_W'(LINE_60 / 2);

    logic [CYC_W-1:0] cyc;
    logic [CYC_W-1:0] last_cur;
    logic [CYC_W-1:0] half_cur;
    logic [CYC_W-1:0] half_nxt;
    logic             mid_end;

    // Select the line limits for the current and the next field.
    always_comb begin
        last_cur = std_cur ? LAST_60 : LAST_50;
        half_cur = std_cur ? HALF_60 : HALF_50;
        half_nxt = std_nxt ? HALF_60 : HALF_50;
    end

    assign line_end   = (cyc == last_cur);
    assign mid_end    = (cyc == half_cur - CYC_W'(1));
    assign half_tick  = line_end | mid_end;
    assign line_start = (cyc == '0);
    assign half_begin = (cyc == '0) | (cyc == half_cur);

    // Step the cycle-in-line counter, resyncing its phase on a mid-line field wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cyc <= '0;
        else if (line_end)
            cyc <= '0;
        else if (mid_end && wrap)
            cyc <= half_nxt;
        else
            cyc <= cyc + CYC_W'(1);
    end

    assert_line_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |=> !line_start);

endmodule

// File: rtl/raster_field_seq.sv
// Module raster_field_seq
// Counts the half-lines inside a field and steps through the field sequence of the
// captured raster mode. It captures the mode and standard inputs only at a field
// wrap or during reset.
// Assumes the mode inputs hold steady while reset is low.
module raster_field_seq
    import raster_pkg::*;
#(
    parameter int BASE_HALVES = 625,
    localparam int HALF_W     = $clog2(2 * BASE_HALVES + 2)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_sel,
    input  logic       std_sel,
    input  logic       half_tick,
    input  logic       half_begin,
    output logic       wrap,
    output logic       field_start,
    output logic       field_id,
    output logic       std_q
);

    raster_mode_e      mode_q;
    raster_mode_e      mode_in;
    logic [1:0]        seq;
    logic [HALF_W-1:0] hcnt;
    logic [HALF_W-1:0] flen;

    assign mode_in = raster_mode_e'(mode_sel);

    // Length of the running field in half-lines.
    always_comb flen = HALF_W'(field_halves(mode_q, seq, BASE_HALVES));

    assign wrap        = half_tick && (hcnt == flen - HALF_W'(1));
    assign field_start = (hcnt == '0) && half_begin;
    assign field_id    = field_label(mode_q, seq);

    // Advance the half-line count, and at a wrap capture the mode and step the sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hcnt   <= '0;
            seq    <= 2'd0;
            mode_q <= mode_in;
            std_q  <= std_sel;
        end else if (wrap) begin
            hcnt   <= '0;
            mode_q <= mode_in;
            std_q  <= std_sel;
            seq    <= (mode_in != mode_q) ? 2'd0 : seq + 2'd1;
        end else if (half_tick) begin
            hcnt   <= hcnt + HALF_W'(1);
        end
    end

    assert_mode_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mode_q) |-> field_start);

    assert_hcnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hcnt < flen);

endmodule

// File: rtl/raster_line_count.sv
// Module raster_line_count
// Numbers the lines of a field from 1.
// Assumes wrap and line_end come from the same timing state.
module raster_line_count #(
    parameter int LN_W = 11
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            line_end,
    input  logic            wrap,
    output logic [LN_W-1:0] line_num
);

    // Restart at 1 for a new field, otherwise count at each line end.
    always_ff @(posedge clk) begin
        if (!rst_n)
            line_num <= LN_W'(1);
        else if (wrap)
            line_num <= LN_W'(1);
        else if (line_end)
            line_num <= line_num + LN_W'(1);
    end

endmodule

// File: rtl/raster_field_sequencer.sv
// Module raster_field_sequencer
// Top of the display raster sequencer. It joins the line timer, the field sequencer
// and the line counter.
// Assumes quasi-static mode inputs, even line lengths and BASE_HALVES >= 2.
module raster_field_sequencer #(
    parameter int  LINE_50     = 864,
    parameter int  LINE_60     = 858,
    parameter int  BASE_HALVES = 625,
    localparam int LN_W        = $clog2(BASE_HALVES + 3) + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      mode_sel,
    input  logic            std_sel,
    output logic            line_start,
    output logic            field_start,
    output logic            field_id,
    output logic [LN_W-1:0] line_num
);

    logic std_q;
    logic wrap;
    logic line_end;
    logic half_tick;
    logic half_begin;

    raster_line_timer #(
        .LINE_50 (LINE_50),
        .LINE_60 (LINE_60)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .std_cur    (std_q),
        .std_nxt    (std_sel),
        .wrap       (wrap),
        .line_start (line_start),
        .line_end   (line_end),
        .half_tick  (half_tick),
        .half_begin (half_begin)
    );

    raster_field_seq #(
        .BASE_HALVES (BASE_HALVES)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_sel    (mode_sel),
        .std_sel     (std_sel),
        .half_tick   (half_tick),
        .half_begin  (half_begin),
        .wrap        (wrap),
        .field_start (field_start),
        .field_id    (field_id),
        .std_q       (std_q)
    );

    raster_line_count #(
        .LN_W (LN_W)
    ) u_lines (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_end (line_end),
        .wrap     (wrap),
        .line_num (line_num)
    );

    assert_field_line1_R9: assert property (@(posedge clk) disable iff (!rst_n)
        field_start |-> (line_num == LN_W'(1)));

    assert_line_inc_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (line_start && !field_start) |-> (line_num == $past(line_num) + LN_W'(1)));

    assert_field_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        field_start |=> !field_start);

endmodule

// File: tb/sim_raster_field_sequencer.sv
`timescale 1ns/1ps
// Bench for raster_field_sequencer, built with short lines and a small base field.
module sim_raster_field_sequencer;

    localparam int L50  = 16;
    localparam int L60  = 14;
    localparam int BASE = 7;
    localparam int LNW  = $clog2(BASE + 3) + 1;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [1:0]     mode_sel = 2'b00;
    logic           std_sel = 1'b0;
    logic           line_start, field_start, field_id;
    logic [LNW-1:0] line_num;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    bit chg_run = 0;

    // Reference model state
    int m_mode, m_std, m_seq, m_sp, m_pos, m_f;

    always #5 clk = ~clk;

    raster_field_sequencer #(.LINE_50(L50), .LINE_60(L60), .BASE_HALVES(BASE)) u0 (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .std_sel(std_sel),
        .line_start(line_start), .field_start(field_start),
        .field_id(field_id), .line_num(line_num));

    function automatic int fh(int md, int s);
        case (md)
            0: return BASE;
            1: return (s == 0) ? BASE + 1 : (s == 2) ? BASE - 1 : BASE;
            2: return 2 * BASE;
            default: return (s % 2 == 0) ? 2 * BASE + 1 : 2 * BASE - 1;
        endcase
    endfunction

    function automatic int fid(int md, int s);
        case (md)
            0: return s % 2;
            1: return s / 2;
            2: return 0;
            default: return s % 2;
        endcase
    endfunction

    function automatic string mtag(int md);
        case (md)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d (mode %0d pos %0d)",
                     tag, what, act, exp, m_mode, m_pos);
        end
    endtask

    // Compare all outputs with the arithmetic model for the present cycle.
    task automatic chk_cycle();
        int h, l, off;
        h = (m_std != 0 ? L60 : L50) / 2;
        l = 2 * h;
        off = m_pos + m_sp * h;
        chk((m_pos == 0 && m_sp == 1) ? "R6" : "R1", "line_start",
            int'(line_start), int'(off % l == 0));
        chk(chg_run ? "R7" : (m_pos == 0 ? mtag(m_mode) : "R10"), "field_start",
            int'(field_start), int'(m_pos == 0));
        chk(chg_run ? "R7" : mtag(m_mode), "field_id", int'(field_id), fid(m_mode, m_seq));
        chk("R9", "line_num", int'(line_num), off / l + 1);
    endtask

    // Advance the model by one cycle using the inputs the design will sample.
    task automatic advance();
        int h, nm;
        h = (m_std != 0 ? L60 : L50) / 2;
        if (m_pos == m_f * h - 1) begin
            nm = int'(mode_sel);
            m_seq = (nm != m_mode) ? 0 : (m_seq + 1) % 4;
            m_sp = (m_sp + m_f) % 2;
            m_mode = nm;
            m_std = int'(std_sel);
            m_f = fh(m_mode, m_seq);
            m_pos = 0;
        end else begin
            m_pos++;
        end
        @(negedge clk);
        #1;
    endtask

    task automatic do_reset(int md, int sd);
        @(negedge clk);
        #1;
        rst_n = 1'b0;
        mode_sel = 2'(md);
        std_sel = 1'(sd);
        @(negedge clk);
        #1;
        // R8: reset state
        chk("R8", "rst field_start", int'(field_start), 1);
        chk("R8", "rst line_start", int'(line_start), 1);
        chk("R8", "rst line_num", int'(line_num), 1);
        chk("R8", "rst field_id", int'(field_id), 0);
        @(negedge clk);
        #1;
        rst_n = 1'b1;
        m_mode = md; m_std = sd; m_seq = 0; m_sp = 0; m_pos = 0;
        m_f = fh(md, 0);
    endtask

    initial begin
        for (int sd = 0; sd < 2; sd++) begin
            for (int md = 0; md < 4; md++) begin
                do_reset(md, sd);
                for (int i = 0; i < 600; i++) begin
                    chk_cycle();
                    advance();
                end
            end
        end
        // R7: mode and standard changes mid-field
        chg_run = 1;
        do_reset(0, 0);
        for (int i = 0; i < 900; i++) begin
            chk_cycle();
            if (i == 50)  mode_sel = 2'b01;
            if (i == 200) std_sel = 1'b1;
            if (i == 330) mode_sel = 2'b11;
            if (i == 600) begin
                mode_sel = 2'b10;
                std_sel = 1'b0;
            end
            advance();
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule